// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital feedback divider of an integer-N frequency synthesizer. Its clock input stands in for the RF input, and every rising edge of that clock counts as one input edge. A dual-modulus prescaler divides the edges by P or by P+1. A programmable B counter counts prescaler cycles, and a swallow A counter keeps the prescaler at P+1 for the first A of those cycles. The block emits one single-cycle pulse every N = P·B + A input edges. It also drives the modulus-control line that selects P+1.

A 2-bit code selects the prescaler base P. The B and A values are held by the block and reloaded only where one output period ends and the next begins. A synchronous counter-reset input returns the divider to its load state, and counting resumes on the first edge after the input is released. A combinational flag reports when the B/A values on the inputs break the legality rules.

Top module: `swallow_divider`

## Requirements
- R1: The prescaler select code sets P: code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 64. The alternate modulus is P+1.
- R2: With legal, unchanging inputs, consecutive output pulses are exactly P·B + A input edges apart.
- R3: While counter-reset is high, no output pulse occurs and the divider reloads from the inputs on each edge. After counter-reset is released, the first pulse follows the N-th edge counted from that release.
- R4: Within each output period, modulus control is high for the first A prescaler cycles, which is A·(P+1) input edges, and is low for the rest. With A = 0 it stays low for the whole period.
- R5: Each output pulse lasts exactly one clock cycle.
- R6: B, A and the prescaler code are taken only at a period boundary (the edge that raises the pulse) or during counter-reset. A change on these inputs in the middle of a period does not alter the length of that period.
- R7: The illegal flag is high exactly when B < 3 or B < A, taken from the present inputs. A = 0 and B = A are legal.
- R8: While reset is active, the pulse and modulus control are both low. The first edge after reset release loads the inputs, so the first pulse follows edge N+1 counted from the release.
- R9: The gap-free lower bound settings B = P−1 with A = 0 (N = 56, 240, 992, 4032) divide correctly. So does the full-swallow case B = A, which gives N = B·(P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input edge clock, standing in for the RF input |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter reset; holds the divider in its load state |
| psel | input | 2 | Prescaler select code |
| b_val | input | 13 | Programmable B counter value |
| a_val | input | 6 | Swallow A counter value |
| div_pulse | output | 1 | Single-cycle pulse once per output period |
| mod_ctl | output | 1 | Modulus control; high selects P+1 |
| cfg_illegal | output | 1 | High when the present B/A values are illegal |

## Verification
The bench builds the block with its default parameters: 13-bit B, 6-bit A, a 2-bit select and a smallest prescaler of 8. These values bring all four moduli within reach, along with the full swallow range of A. The B values are kept near A or near P−1, so that even the 64/65 setting, including its lowest gap-free N of 4032, completes several full periods within the run. At those settings the bench measures pulse spacing, the first-pulse latency after each kind of reset, the count of modulus-control cycles per period, and how a change in mid-period takes effect.

// File: rtl/swd_pkg.sv
package swd_pkg;

    // Prescaler select codes, ordered by rising base modulus
    typedef enum logic [1:0] {
        PS_BASE_X1 = 2'd0,
        PS_BASE_X2 = 2'd1,
        PS_BASE_X4 = 2'd2,
        PS_BASE_X8 = 2'd3
    } psel_e;

    // Smallest number of B cycles that a legal setting may use
    localparam int unsigned LEGAL_B_MIN = 3;

endpackage

// File: rtl/swd_modulus.sv
// Gives the reload value (cycle length minus one) of one prescaler cycle
module swd_modulus #(
    parameter int PSEL_W    = 2,
    parameter int BASE_LOG2 = 3,
    localparam int NCODE    = 1 << PSEL_W,
    localparam int PC_W     = BASE_LOG2 + NCODE
) (
    input  logic [PSEL_W-1:0] code,
    input  logic              swallow,
    output logic [PC_W-1:0]   reload
);

    logic [PC_W-1:0] p_tab [NCODE];

    for (genvar i = 0; i < NCODE; i++) begin : g_tab
        assign p_tab[i] = PC_W'(1) << (BASE_LOG2 + i);
    end

    // A swallow cycle lasts P+1 edges (reload P); a plain cycle lasts P (reload P-1)
    always_comb begin
        if (swallow) begin
            reload = p_tab[code];
        end else begin
            reload = p_tab[code] - PC_W'(1);
        end
    end

endmodule

// File: rtl/swd_legal.sv
// Flags B/A settings outside the legal range
module swd_legal #(
    parameter int B_W   = 13,
    parameter int A_W   = 6,
    parameter int B_MIN = 3
) (
    input  logic [B_W-1:0] b_in,
    input  logic [A_W-1:0] a_in,
    output logic           illegal
);

    logic [B_W-1:0] a_wide;

    always_comb begin
        a_wide  = {{(B_W-A_W){1'b0}}, a_in};
        illegal = (b_in < B_W'(B_MIN)) || (a_wide > b_in);
    end

endmodule

// File: rtl/swd_core.sv
// Prescaler position, B count and swallow count, two-process style
module swd_core #(
    parameter int B_W       = 13,
    parameter int A_W       = 6,
    parameter int PSEL_W    = 2,
    parameter int BASE_LOG2 = 3,
    localparam int NCODE    = 1 << PSEL_W,
    localparam int PC_W     = BASE_LOG2 + NCODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst,
    input  logic [PSEL_W-1:0] psel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    output logic              div_pulse,
    output logic              mod_ctl
);

    typedef struct packed {
        logic              loaded;
        logic [PSEL_W-1:0] code;
        logic [B_W-1:0]    bcnt;
        logic [A_W-1:0]    acnt;
        logic [PC_W-1:0]   pcnt;
        logic              pulse;
    } st_t;

    st_t st_d, st_q;

    logic            ld_swallow;
    logic [PC_W-1:0] ld_reload;
    logic [A_W-1:0]  run_acnt;
    logic            run_swallow;
    logic [PC_W-1:0] run_reload;

    // First cycle length of a fresh period, from the incoming settings
    swd_modulus #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_mod_load (
        .code    (psel),
        .swallow (ld_swallow),
        .reload  (ld_reload)
    );

    // Next cycle length inside a running period, from the held code
    swd_modulus #(.PSEL_W(PSEL_W), .BASE_LOG2(BASE_LOG2)) u_mod_run (
        .code    (st_q.code),
        .swallow (run_swallow),
        .reload  (run_reload)
    );

    always_comb begin
        ld_swallow  = (a_val != '0);
        run_acnt    = (st_q.acnt != '0) ? st_q.acnt - A_W'(1) : '0;
        run_swallow = (run_acnt != '0);

        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (!st_q.loaded || cnt_rst) begin
            // load state: take the inputs, no pulse
            st_d.loaded = 1'b1;
            st_d.code   = psel;
            st_d.bcnt   = b_val;
            st_d.acnt   = a_val;
            st_d.pcnt   = ld_reload;
        end else if (st_q.pcnt != '0) begin
            st_d.pcnt = st_q.pcnt - PC_W'(1);
        end else if (st_q.bcnt <= B_W'(1)) begin
            // last prescaler cycle of the period ends: pulse and reload
            st_d.pulse = 1'b1;
            st_d.code  = psel;
            st_d.bcnt  = b_val;
            st_d.acnt  = a_val;
            st_d.pcnt  = ld_reload;
        end else begin
            st_d.bcnt = st_q.bcnt - B_W'(1);
            st_d.acnt = run_acnt;
            st_d.pcnt = run_reload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse = st_q.pulse;
    assign mod_ctl   = (st_q.acnt != '0);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int B_W       = 13,
    parameter int A_W       = 6,
    parameter int PSEL_W    = 2,
    parameter int BASE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst,
    input  logic [PSEL_W-1:0] psel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    output logic              div_pulse,
    output logic              mod_ctl,
    output logic              cfg_illegal
);

    swd_core #(
        .B_W       (B_W),
        .A_W       (A_W),
        .PSEL_W    (PSEL_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_rst   (cnt_rst),
        .psel      (psel),
        .b_val     (b_val),
        .a_val     (a_val),
        .div_pulse (div_pulse),
        .mod_ctl   (mod_ctl)
    );

    swd_legal #(
        .B_W   (B_W),
        .A_W   (A_W),
        .B_MIN (swd_pkg::LEGAL_B_MIN)
    ) u_legal (
        .b_in    (b_val),
        .a_in    (a_val),
        .illegal (cfg_illegal)
    );

endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int B_W    = 13,
    parameter int A_W    = 6,
    parameter int PSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_rst,
    input logic [PSEL_W-1:0] psel,
    input logic [B_W-1:0]    b_val,
    input logic [A_W-1:0]    a_val,
    input logic              div_pulse,
    input logic              mod_ctl,
    input logic              cfg_illegal
);

    logic [B_W-1:0] a_ext;
    assign a_ext = {{(B_W-A_W){1'b0}}, a_val};

    assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !div_pulse);

    assert_load_modctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (mod_ctl == ($past(a_val) != '0)));

    assert_boundary_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (mod_ctl == ($past(a_val) != '0)));

    assert_flag_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal == ((b_val < B_W'(3)) || (a_ext > b_val)));

endmodule

bind swallow_divider swd_checker #(
    .B_W    (B_W),
    .A_W    (A_W),
    .PSEL_W (PSEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_rst     (cnt_rst),
    .psel        (psel),
    .b_val       (b_val),
    .a_val       (a_val),
    .div_pulse   (div_pulse),
    .mod_ctl     (mod_ctl),
    .cfg_illegal (cfg_illegal)
);

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 30000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_rst = 1'b0;
    logic [1:0]  psel = 2'd0;
    logic [12:0] b_val = 13'd0;
    logic [5:0]  a_val = 6'd0;
    logic        div_pulse, mod_ctl, cfg_illegal;

    int total = 0;
    int bad = 0;
    int ecount = 0;
    bit done = 1'b0;

    swallow_divider u_swallow_divider (
        .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .psel(psel),
        .b_val(b_val), .a_val(a_val), .div_pulse(div_pulse),
        .mod_ctl(mod_ctl), .cfg_illegal(cfg_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    function automatic int p_of(input logic [1:0] code);
        return 8 << code;
    endfunction

    function automatic int n_of(input logic [1:0] code, input int b, input int a);
        return p_of(code) * b + a;
    endfunction

    function automatic bit illegal_of(input int b, input int a);
        return (b < 3) || (b < a);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for the next pulse; m counts mod_ctl-high samples before it
    task automatic wait_pulse(output int e, output int m);
        bit seen = 1'b0;
        m = 0;
        e = -1;
        for (int i = 0; i < WAIT_LIMIT; i++) begin
            @(negedge clk);
            if (div_pulse) begin
                e = ecount;
                seen = 1'b1;
                break;
            end
            if (mod_ctl) m++;
        end
        if (!seen) chk(1'b0, "watchdog pulse wait", 0, 1);
    endtask

    task automatic run_cfg(input logic [1:0] code, input int b, input int a, input string req);
        int e0, e1, e2, m1, m2, pm, n;
        n = n_of(code, b, a);
        @(negedge clk);
        psel = code; b_val = 13'(b); a_val = 6'(a); cnt_rst = 1'b1;
        @(negedge clk);
        e0 = ecount;
        chk(div_pulse == 1'b0, "R3 no pulse in counter reset", int'(div_pulse), 0);
        cnt_rst = 1'b0;
        wait_pulse(e1, m1);
        chk(e1 - e0 == n, {"R3 first pulse latency ", req}, e1 - e0, n);
        pm = int'(mod_ctl);
        chk(pm == int'(a != 0), "R4 mod_ctl at period start", pm, int'(a != 0));
        wait_pulse(e2, m2);
        chk(e2 - e1 == n, {"R2 pulse spacing ", req}, e2 - e1, n);
        chk(pm + m2 == a * (p_of(code) + 1), "R4 swallow edges per period",
            pm + m2, a * (p_of(code) + 1));
        @(negedge clk);
        chk(div_pulse == 1'b0, "R5 pulse width", int'(div_pulse), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            chk(1'b0, "watchdog global", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0, e1, e2, e3, m;
        void'($urandom(32'd20240611));

        // R8: reset state and first load after release
        psel = 2'd1; b_val = 13'd4; a_val = 6'd1;
        repeat (3) @(negedge clk);
        chk(div_pulse == 1'b0, "R8 pulse low in reset", int'(div_pulse), 0);
        chk(mod_ctl == 1'b0, "R8 mod_ctl low in reset", int'(mod_ctl), 0);
        rst_n = 1'b1;
        e0 = ecount;
        wait_pulse(e1, m);
        chk(e1 - e0 == n_of(2'd1, 4, 1) + 1, "R8 first pulse after reset",
            e1 - e0, n_of(2'd1, 4, 1) + 1);

        // R7: legality flag
        @(negedge clk); b_val = 13'd2; a_val = 6'd0; #1;
        chk(cfg_illegal == illegal_of(2, 0), "R7 B below 3", int'(cfg_illegal), 1);
        b_val = 13'd5; a_val = 6'd6; #1;
        chk(cfg_illegal == illegal_of(5, 6), "R7 B below A", int'(cfg_illegal), 1);
        b_val = 13'd3; a_val = 6'd3; #1;
        chk(cfg_illegal == illegal_of(3, 3), "R7 B equals A", int'(cfg_illegal), 0);
        b_val = 13'd3; a_val = 6'd0; #1;
        chk(cfg_illegal == illegal_of(3, 0), "R7 A zero", int'(cfg_illegal), 0);

        // R3: held counter reset keeps the divider quiet
        @(negedge clk); psel = 2'd0; cnt_rst = 1'b1;
        m = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (div_pulse) m++;
        end
        chk(m == 0, "R3 held counter reset", m, 0);
        cnt_rst = 1'b0;

        // R1 and R9: directed per prescaler code
        for (int c = 0; c < 4; c++) begin
            int p = 8 << c;
            run_cfg(2'(c), 3, 0, "R1 minimum B, A zero");
            run_cfg(2'(c), p - 1, 0, "R9 gap-free lower bound");
            run_cfg(2'(c), 5, 5, "R9 full swallow B equals A");
            for (int k = 0; k < 2; k++) begin
                int a = int'($urandom % 64);
                int b = a + int'($urandom % 6);
                if (b < 3) b = 3;
                run_cfg(2'(c), b, a, "random legal");
            end
        end

        // R6: mid-period update takes effect only at the boundary
        run_cfg(2'd0, 10, 2, "R6 setup");
        wait_pulse(e1, m);
        repeat (10) @(negedge clk);
        b_val = 13'd20; a_val = 6'd5;
        wait_pulse(e2, m);
        chk(e2 - e1 == n_of(2'd0, 10, 2), "R6 running period kept", e2 - e1, n_of(2'd0, 10, 2));
        wait_pulse(e3, m);
        chk(e3 - e2 == n_of(2'd0, 20, 5), "R6 new period length", e3 - e2, n_of(2'd0, 20, 5));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule